// File: doc/BRIEF.md
# Hamming Sector ECC Corrector

This block judges a single 512-byte sector protected by a 24-bit Hamming code that corrects one bit. A controller hands it two 3-byte codes. The first is the code kept in the spare area of the page. The second is the code regenerated while the sector was streamed in. A one-cycle `start` begins a check. The block expands each 3-byte code into a 32-bit working word and XORs the two words to form a syndrome. It then counts the ones in the syndrome over several cycles, a configurable number of bits per cycle.

When the count is done, the block raises `done` for one cycle. At that point it presents a 2-bit verdict and, for a correctable error, the byte address and bit number that the caller should invert. The block does not compute the code over the data and does not touch the data buffer; it only names the location to fix.

Top module: `hecc_corrector`

## Requirements
- R1: A 3-byte code is given as a 24-bit port holding byte 0 in bits 7:0, byte 1 in bits 15:8 and byte 2 in bits 23:16. Its 32-bit working word carries byte 0 in bits 7:0 and the low nibble of byte 2 in bits 11:8. It carries byte 1 in bits 23:16 and the high nibble of byte 2 in bits 27:24. Every other bit is zero.
- R2: When the two working words are equal, the verdict is 0 (clean) and the fix byte and fix bit are 0.
- R3: When the syndrome holds exactly twelve ones, the verdict is 1 (corrected). The fix bit is syndrome bits 18:16 and the fix byte is syndrome bits 27:19, a value from 0 to 511.
- R4: When the syndrome holds exactly one 1, the verdict is 2 (the stored code is damaged) and the fix byte and fix bit are 0.
- R5: When the stored working word is 0x0FFF0FFF and the computed working word is 0, the sector counts as erased and the verdict is 0 with fix byte and fix bit 0.
- R6: Any other nonzero syndrome gives verdict 3 (uncorrectable) with fix byte and fix bit 0.
- R7: `busy` is high from the cycle after an accepted `start` until `done`. `done` is high for exactly one cycle per accepted `start`, and `busy` is low while `done` is high.
- R8: A `start` that arrives while `busy` is high is ignored: the result that follows belongs to the accepted request, and no extra `done` appears.
- R9: The verdict, fix byte and fix bit keep their values from `done` until the next accepted request completes.
- R10: After reset, `busy`, `done`, the verdict, the fix byte and the fix bit are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a check with the codes present this cycle |
| stored_code | input | 24 | Code read from the spare area, byte 0 in the low bits |
| calc_code | input | 24 | Code recomputed over the sector data |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| verdict | output | 2 | 0 clean, 1 corrected, 2 code damaged, 3 uncorrectable |
| fix_byte | output | 9 | Byte address to invert (valid for verdict 1) |
| fix_bit | output | 3 | Bit number to invert (valid for verdict 1) |

## Verification
The embedded assertions assume that the caller holds both codes steady only in the cycle `start` is high. They also assume the caller may pulse `start` at any time, including while a check is running. Under those assumptions, the assertions check that the captured syndrome is frozen during a check and that the ones counter is never reloaded mid-count. The stimulus respects this by changing codes only at the falling clock edge, and it deliberately fires a second `start` with different codes in the middle of a running check. Random codes give mostly uncorrectable syndromes. The bench therefore also builds syndromes with exactly twelve ones (complementary halves), with single ones, with equal codes and with the erased pattern, so that every verdict is reached.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

    localparam int SECTOR_BYTES = 512;
    localparam int CODE_W       = 24;
    localparam int WORD_W       = 32;
    localparam int BYTE_IDX_W   = $clog2(SECTOR_BYTES);
    localparam int BIT_IDX_W    = 3;
    localparam int CNT_W        = $clog2(WORD_W + 1);
    localparam int HALF_LO      = 16;

    localparam logic [WORD_W-1:0] ERASED_STORED_WORD = 32'h0FFF_0FFF;
    localparam logic [CNT_W-1:0]  ONES_CORRECTABLE   = CNT_W'(12);
    localparam logic [CNT_W-1:0]  ONES_CODE_FAULT    = CNT_W'(1);

    typedef enum logic [1:0] {
        VERDICT_CLEAN     = 2'd0,
        VERDICT_FIXED     = 2'd1,
        VERDICT_CODE_BAD  = 2'd2,
        VERDICT_UNCORR    = 2'd3
    } verdict_e;

    typedef struct packed {
        verdict_e               kind;
        logic [BYTE_IDX_W-1:0]  byte_idx;
        logic [BIT_IDX_W-1:0]   bit_idx;
    } result_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Expand a packed 3-byte code into the 32-bit working layout.
    function automatic logic [WORD_W-1:0] expand_code(input logic [CODE_W-1:0] c);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[7:0]   = c[7:0];
        w[11:8]  = c[19:16];
        w[23:16] = c[15:8];
        w[27:24] = c[23:20];
        return w;
    endfunction

endpackage

// File: rtl/hecc_expand.sv
module hecc_expand
    import hecc_pkg::*;
(
    input  logic [CODE_W-1:0] code_in,
    output logic [WORD_W-1:0] word_out
);
    always_comb word_out = expand_code(code_in);
endmodule

// File: rtl/hecc_popcnt.sv
module hecc_popcnt
    import hecc_pkg::*;
#(
    parameter int LANE = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [WORD_W-1:0]  value,
    output logic               cnt_valid,
    output logic [CNT_W-1:0]   cnt
);
    localparam int NSTEP = WORD_W / LANE;
    localparam int IDX_W = (NSTEP > 1) ? $clog2(NSTEP) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSTEP - 1);

    logic [WORD_W-1:0] val_q;
    logic [CNT_W-1:0]  acc_q;
    logic [IDX_W-1:0]  idx_q;
    logic              run_q;
    logic [LANE-1:0]   chunk;
    logic [CNT_W-1:0]  lane_ones;

    always_comb begin
        chunk = val_q[idx_q * LANE +: LANE];
        lane_ones = '0;
        for (int i = 0; i < LANE; i++) begin
            lane_ones = lane_ones + {{(CNT_W-1){1'b0}}, chunk[i]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q     <= '0;
            acc_q     <= '0;
            idx_q     <= '0;
            run_q     <= 1'b0;
            cnt_valid <= 1'b0;
        end else begin
            cnt_valid <= 1'b0;
            if (load) begin
                val_q <= value;
                acc_q <= '0;
                idx_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                acc_q <= acc_q + lane_ones;
                if (idx_q == LAST_IDX) begin
                    run_q     <= 1'b0;
                    cnt_valid <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign cnt = acc_q;

    // R8: the owner never reloads the counter in the middle of a count
    assert_no_reload_R8: assert property (@(posedge clk) disable iff (rst)
        load |-> !run_q);

    // R3: a finished count never exceeds the word width
    assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_valid |-> (cnt <= CNT_W'(WORD_W)));

endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
    import hecc_pkg::*;
(
    input  logic [WORD_W-1:0] syndrome,
    input  logic [WORD_W-1:0] stored_word,
    input  logic [WORD_W-1:0] calc_word,
    input  logic [CNT_W-1:0]  ones,
    output result_t           result
);
    logic is_erased;

    always_comb begin
        is_erased = (stored_word == ERASED_STORED_WORD) && (calc_word == '0);
        result    = '{kind: VERDICT_CLEAN, byte_idx: '0, bit_idx: '0};
        if (syndrome == '0 || is_erased) begin
            result.kind = VERDICT_CLEAN;
        end else if (ones == ONES_CORRECTABLE) begin
            result.kind     = VERDICT_FIXED;
            result.bit_idx  = syndrome[HALF_LO +: BIT_IDX_W];
            result.byte_idx = syndrome[HALF_LO + BIT_IDX_W +: BYTE_IDX_W];
        end else if (ones == ONES_CODE_FAULT) begin
            result.kind = VERDICT_CODE_BAD;
        end else begin
            result.kind = VERDICT_UNCORR;
        end
    end
endmodule

// File: rtl/hecc_corrector.sv
module hecc_corrector
    import hecc_pkg::*;
#(
    parameter int POP_LANE = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [23:0] stored_code,
    input  logic [23:0] calc_code,
    output logic        busy,
    output logic        done,
    output logic [1:0]  verdict,
    output logic [8:0]  fix_byte,
    output logic [2:0]  fix_bit
);
    phase_e            phase_q;
    logic [WORD_W-1:0] stored_w, calc_w;
    logic [WORD_W-1:0] stored_q, calc_q, syn_q;
    logic              accept;
    logic              cnt_valid;
    logic [CNT_W-1:0]  ones;
    result_t           verdict_next;
    result_t           result_q;
    logic              done_q;

    hecc_expand u_exp_stored (.code_in(stored_code), .word_out(stored_w));
    hecc_expand u_exp_calc   (.code_in(calc_code),   .word_out(calc_w));

    assign accept = start && (phase_q == PH_IDLE);

    hecc_popcnt #(.LANE(POP_LANE)) u_pop (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .value     (stored_w ^ calc_w),
        .cnt_valid (cnt_valid),
        .cnt       (ones)
    );

    hecc_classify u_cls (
        .syndrome    (syn_q),
        .stored_word (stored_q),
        .calc_word   (calc_q),
        .ones        (ones),
        .result      (verdict_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            stored_q <= '0;
            calc_q   <= '0;
            syn_q    <= '0;
            result_q <= '{kind: VERDICT_CLEAN, byte_idx: '0, bit_idx: '0};
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        stored_q <= stored_w;
                        calc_q   <= calc_w;
                        syn_q    <= stored_w ^ calc_w;
                        phase_q  <= PH_RUN;
                    end
                end
                PH_RUN: begin
                    if (cnt_valid) begin
                        result_q <= verdict_next;
                        done_q   <= 1'b1;
                        phase_q  <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy     = (phase_q == PH_RUN);
    assign done     = done_q;
    assign verdict  = result_q.kind;
    assign fix_byte = result_q.byte_idx;
    assign fix_bit  = result_q.bit_idx;

    // R7: completion is a single-cycle pulse
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: the block is never busy while it reports completion
    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8: a start while busy leaves the captured syndrome untouched
    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(syn_q));

    // R9: outputs only move on the cycle that reports completion
    assert_hold_result_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(verdict) && $stable(fix_byte) && $stable(fix_bit)));

    // R2: no location is named unless the verdict is a correction
    assert_index_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (verdict != VERDICT_FIXED) |-> (fix_byte == '0 && fix_bit == '0));

endmodule

// File: tb/tb_hecc_corrector.sv
module tb_hecc_corrector;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [23:0] stored_code = '0;
    logic [23:0] calc_code = '0;
    logic        busy, done;
    logic [1:0]  verdict;
    logic [8:0]  fix_byte;
    logic [2:0]  fix_bit;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    hecc_corrector dut (
        .clk(clk), .rst(rst), .start(start),
        .stored_code(stored_code), .calc_code(calc_code),
        .busy(busy), .done(done), .verdict(verdict),
        .fix_byte(fix_byte), .fix_bit(fix_bit)
    );

    // R1 layout, bench side
    function automatic logic [31:0] widen(input logic [23:0] c);
        return {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
    endfunction

    // Packed form of a 12-bit location with complementary halves
    function automatic logic [23:0] loc_diff(input logic [11:0] p);
        logic [11:0] n;
        n = ~p;
        return {p[11:8], n[11:8], p[7:0], n[7:0]};
    endfunction

    function automatic logic [13:0] model(input logic [23:0] s, input logic [23:0] c);
        logic [31:0] a, b, d;
        a = widen(s);
        b = widen(c);
        d = a ^ b;
        if (d == 0) return {2'd0, 12'd0};
        if (a == 32'h0FFF0FFF && b == 0) return {2'd0, 12'd0};
        if ($countones(d) == 12) return {2'd1, d[27:19], d[18:16]};
        if ($countones(d) == 1) return {2'd2, 12'd0};
        return {2'd3, 12'd0};
    endfunction

    task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Launch one check, optionally firing a second start mid-run.
    task automatic run_one(input logic [23:0] s, input logic [23:0] c,
                           input bit poke, input string req);
        logic [13:0] exp;
        int waited;
        exp = model(s, c);
        @(negedge clk);
        stored_code = s; calc_code = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        stored_code = ~s; calc_code = s;
        check("R7 busy after start", {13'd0, busy}, 14'd1);
        if (poke) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        check("R7 done seen", {13'd0, done}, 14'd1);
        check("R7 not busy at done", {13'd0, busy}, 14'd0);
        check(req, {verdict, fix_byte, fix_bit}, exp);
        @(negedge clk);
        check("R7 done one cycle", {13'd0, done}, 14'd0);
        if (poke) begin
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                check("R8 no extra done", {13'd0, done}, 14'd0);
                check("R9 result held", {verdict, fix_byte, fix_bit}, exp);
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [23:0] s;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset", {busy, done, verdict, fix_byte, fix_bit}, 14'd0);
        check("R10 reset x", {12'd0, busy, done}, 14'd0);

        // directed corners
        run_one(24'h123456, 24'h123456, 0, "R2 equal codes");
        run_one(24'hFFFFFF, 24'h000000, 0, "R5 erased page");
        run_one(24'hFFFFFF, 24'h000001, 0, "R6 near-erased");
        run_one(24'h000000, 24'h000000 ^ loc_diff(12'hFFF), 0, "R3 last byte bit 7");
        run_one(24'hA5A5A5, 24'hA5A5A5 ^ loc_diff(12'h000), 0, "R3 byte 0 bit 0");
        run_one(24'h000000, 24'h100000, 0, "R4 high nibble single bit R1");
        run_one(24'h000000, 24'h000100, 0, "R4 byte1 single bit R1");
        run_one(24'h000000, 24'h030000, 0, "R6 two bits");
        run_one(24'h5A0F33, 24'h5A0F33 ^ loc_diff(12'h2C5), 1, "R8 poke during correction");
        run_one(24'h000000, 24'hFFFFFF, 1, "R6 poke during uncorrectable");

        // random mix
        for (int i = 0; i < 40; i++) begin
            s = 24'($urandom);
            run_one(s, 24'($urandom), (i % 7) == 0, "R6 random pair");
        end
        for (int i = 0; i < 40; i++) begin
            s = 24'($urandom);
            run_one(s, s ^ loc_diff(12'($urandom)), (i % 9) == 0, "R3 random location");
        end
        for (int i = 0; i < 20; i++) begin
            s = 24'($urandom);
            run_one(s, s ^ (24'd1 << ($urandom % 24)), 0, "R4 random single bit");
        end
        for (int i = 0; i < 5; i++) begin
            s = 24'($urandom);
            run_one(s, s, 0, "R2 random equal");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule